// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the chain of extended capability headers stored in a 4 KB configuration space. Each header is one 32-bit word. The chain starts at byte offset 0x100, and every header carries a pointer to the next one. After a start pulse the engine reads headers one at a time through a synchronous memory port. It stops at the first header whose ID equals the requested ID, or at the end of the chain. It then reports the offset it found and the offset of the header visited just before it. A search for ID 0 (a reserved value) runs to the end of the chain, so the reported previous offset is the current tail.

The same engine can also link a new header into the chain. When the new entry goes at 0x100, it takes over the next pointer of the word already stored there. In every other case the engine first finds the tail. It then rewrites the tail's next pointer to the new offset and writes the new header with a null next pointer. Choosing where the space comes from and what the capability body holds is up to the caller.

Top module: `ecap_list_walker`

## Requirements
- R1: A header word holds the ID in bits [15:0], a version in bits [19:16] and the next byte offset in bits [31:20]. Only the ID takes part in matching.
- R2: Every operation begins by reading offset 0x100. If a search finds that word all zero, it finishes with found=0, offset=0, prev_offset=0 and error=0.
- R3: When a header's ID matches the target, the search finishes with found=1, offset equal to that header's offset, and prev_offset equal to the header read just before it (0 when the match is at 0x100).
- R4: A next pointer of 0 ends a search with found=0 and offset=0, and prev_offset is the last header read. A search for ID 0 therefore returns the tail in prev_offset.
- R5: A next pointer whose two low bits are not 00 ends the operation with error=1 and found=0.
- R6: A next pointer below 0x100 or above 0xFF8 ends the operation with error=1. The value 0xFF8 itself is followed.
- R7: When MAX_STEPS headers (default 1024) have been read and the chain still continues, the operation ends with error=1. This stops endless walks on a cyclic chain.
- R8: An append at offset 0x100 reads that word once and performs exactly one write there: {old next field, new version, new ID}. It reports found=1, offset=0x100 and prev_offset=0.
- R9: An append at any other offset finds the tail, then writes two words. First it writes the tail with its next field replaced by the new offset and bits [19:0] kept. Then it writes {0, version, ID} at the new offset. It reports found=1, offset=new offset and prev_offset=tail.
- R10: An append is rejected with error=1 and no memory access when any of these holds: the offset is below 0x100, the offset is not a multiple of 4, the size is below 8, or offset+size is not below 4096. An append at an offset other than 0x100 also ends with error=1 and no write when the chain is empty or the ID-0 walk matches.
- R11: A start pulse while busy is ignored. The running operation keeps its target and finishes with unchanged results and timing.
- R12: After reset, done, busy and both memory enables are 0. Each completion raises done for exactly one cycle, and the result outputs stay valid until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_append | input | 1 | 0 = search, 1 = append |
| target_id | input | 16 | ID searched for, or ID of the new entry |
| app_offset | input | 12 | Byte offset of the new entry |
| app_version | input | 4 | Version of the new entry |
| app_size | input | 13 | Size in bytes of the new entry |
| mem_rd_en | output | 1 | Read request; data returns the next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | 12 | Byte address for the read or the write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Match found or append done |
| res_offset | output | 12 | Offset of the match or of the new entry |
| res_prev | output | 12 | Offset of the header before the result |
| error | output | 1 | Operation failed |

## Verification
Count the clock edge that samples start as edge 1. Each header read then costs two edges: one to issue the read and one to evaluate the returned word. A search that reads k headers raises done after edge 2k+1. An append at 0x100 raises done after edge 4. An append that reads k headers raises done after edge 2k+3. A rejected append raises done after edge 1. The bench drives inputs at falling edges and counts rising edges until done is seen at a falling edge. It compares that count with these formulas, and it checks outputs and the written memory words at the same falling edge.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;
  localparam int OFF_W  = 12;
  localparam int ID_W   = 16;
  localparam int VER_W  = 4;
  localparam int HDR_W  = 32;
  localparam int SIZE_W = 13;
  localparam int CFG_BYTES = 4096;
  localparam logic [OFF_W-1:0] CAP_BASE = OFF_W'(256);
  localparam logic [OFF_W-1:0] LAST_HDR = OFF_W'(CFG_BYTES - 8);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_EV, ST_PATCH, ST_NEW} walk_st_e;

  function automatic logic [ID_W-1:0] hdr_id(input logic [HDR_W-1:0] h);
    return h[ID_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] hdr_next(input logic [HDR_W-1:0] h);
    return h[HDR_W-1 -: OFF_W];
  endfunction

  function automatic logic [HDR_W-1:0] hdr_make(input logic [ID_W-1:0] id,
                                                input logic [VER_W-1:0] ver,
                                                input logic [OFF_W-1:0] nxt);
    return {nxt, ver, id};
  endfunction

  function automatic logic [HDR_W-1:0] hdr_relink(input logic [HDR_W-1:0] h,
                                                  input logic [OFF_W-1:0] nxt);
    return {nxt, h[ID_W+VER_W-1:0]};
  endfunction

  function automatic logic ptr_legal(input logic [OFF_W-1:0] p);
    return (p[1:0] == 2'b00) && (p >= CAP_BASE) && (p <= LAST_HDR);
  endfunction

  function automatic logic append_legal(input logic [OFF_W-1:0] off,
                                        input logic [SIZE_W-1:0] size);
    logic [OFF_W+1:0] end_pos;
    end_pos = (OFF_W+2)'(off) + (OFF_W+2)'(size);
    return (off >= CAP_BASE) && (off[1:0] == 2'b00) &&
           (size >= SIZE_W'(8)) && (end_pos < (OFF_W+2)'(CFG_BYTES));
  endfunction
endpackage

// File: rtl/ecap_hdr_eval.sv
module ecap_hdr_eval
  import ecap_walk_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  input  logic [ID_W-1:0]  target,
  output logic             hit,
  output logic             at_tail,
  output logic             ptr_bad,
  output logic [OFF_W-1:0] nxt
);
  assign nxt     = hdr_next(hdr);
  assign hit     = (hdr_id(hdr) == target);
  assign at_tail = (nxt == '0);
  assign ptr_bad = !ptr_legal(nxt);
endmodule

// File: rtl/ecap_step_ctr.sv
module ecap_step_ctr #(
  parameter int unsigned MAX_STEPS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_STEPS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == CW'(MAX_STEPS));

  // R7: the header count never passes the limit
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_STEPS));
  // R7: no further read is issued once the limit is reached
  a_r7_no_read_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !inc);
endmodule

// File: rtl/ecap_list_walker.sv
module ecap_list_walker
  import ecap_walk_pkg::*;
#(
  parameter int unsigned MAX_STEPS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_append,
  input  logic [ID_W-1:0]   target_id,
  input  logic [OFF_W-1:0]  app_offset,
  input  logic [VER_W-1:0]  app_version,
  input  logic [SIZE_W-1:0] app_size,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [OFF_W-1:0]  mem_addr,
  output logic [HDR_W-1:0]  mem_wdata,
  input  logic [HDR_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [OFF_W-1:0]  res_offset,
  output logic [OFF_W-1:0]  res_prev,
  output logic              error
);
  walk_st_e st_q, st_d;
  logic [OFF_W-1:0] cur_q, cur_d, prev_q, prev_d, keep_q, keep_d, off_q;
  logic [ID_W-1:0]  tgt_q, id_q;
  logic [VER_W-1:0] ver_q;
  logic [HDR_W-1:0] hdr_q;
  logic             app_q;
  logic             done_q, found_q, err_q;
  logic [OFF_W-1:0] res_q, prv_q;

  // named internal events
  logic             hit, at_tail, ptr_bad, exhausted, accept;
  logic [OFF_W-1:0] nxt;
  logic             fin, fin_found, fin_err;
  logic [OFF_W-1:0] fin_res, fin_prev;

  assign accept = (st_q == ST_IDLE) && start;

  ecap_hdr_eval u_eval (
    .hdr(mem_rdata), .target(tgt_q),
    .hit(hit), .at_tail(at_tail), .ptr_bad(ptr_bad), .nxt(nxt)
  );

  ecap_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
    .clk(clk), .rst_n(rst_n), .clear(accept), .inc(st_q == ST_RD),
    .exhausted(exhausted)
  );

  always_comb begin
    st_d = st_q; cur_d = cur_q; prev_d = prev_q; keep_d = keep_q;
    fin = 1'b0; fin_found = 1'b0; fin_err = 1'b0;
    fin_res = '0; fin_prev = '0;
    case (st_q)
      ST_IDLE: if (start) begin
        cur_d  = CAP_BASE;
        prev_d = '0;
        if (op_append && !append_legal(app_offset, app_size)) begin
          fin = 1'b1; fin_err = 1'b1;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_RD: st_d = ST_EV;
      ST_EV: begin
        if (app_q && off_q == CAP_BASE) begin
          keep_d = hdr_next(mem_rdata);
          st_d   = ST_NEW;
        end else if (cur_q == CAP_BASE && mem_rdata == '0) begin
          fin = 1'b1; fin_err = app_q; st_d = ST_IDLE;
        end else if (hit) begin
          fin = 1'b1; st_d = ST_IDLE;
          if (app_q) fin_err = 1'b1;
          else begin
            fin_found = 1'b1; fin_res = cur_q; fin_prev = prev_q;
          end
        end else if (at_tail) begin
          if (app_q) begin
            prev_d = cur_q; keep_d = '0; st_d = ST_PATCH;
          end else begin
            fin = 1'b1; fin_prev = cur_q; st_d = ST_IDLE;
          end
        end else if (ptr_bad || exhausted) begin
          fin = 1'b1; fin_err = 1'b1; st_d = ST_IDLE;
        end else begin
          prev_d = cur_q; cur_d = nxt; st_d = ST_RD;
        end
      end
      ST_PATCH: st_d = ST_NEW;
      ST_NEW: begin
        fin = 1'b1; fin_found = 1'b1; fin_res = off_q; fin_prev = prev_q;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cur_q <= '0; prev_q <= '0; keep_q <= '0; off_q <= '0;
      tgt_q <= '0; id_q <= '0; ver_q <= '0; hdr_q <= '0; app_q <= 1'b0;
      done_q <= 1'b0; found_q <= 1'b0; err_q <= 1'b0; res_q <= '0; prv_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; prev_q <= prev_d; keep_q <= keep_d;
      if (accept) begin
        tgt_q <= op_append ? '0 : target_id;
        app_q <= op_append;
        id_q  <= target_id;
        ver_q <= app_version;
        off_q <= app_offset;
      end
      if (st_q == ST_EV) hdr_q <= mem_rdata;
      done_q <= fin;
      if (fin) begin
        found_q <= fin_found; err_q <= fin_err;
        res_q   <= fin_res;   prv_q <= fin_prev;
      end
    end
  end

  assign mem_rd_en = (st_q == ST_RD);
  assign mem_wr_en = (st_q == ST_PATCH) || (st_q == ST_NEW);
  always_comb begin
    case (st_q)
      ST_PATCH: begin mem_addr = prev_q; mem_wdata = hdr_relink(hdr_q, off_q); end
      ST_NEW:   begin mem_addr = off_q;  mem_wdata = hdr_make(id_q, ver_q, keep_q); end
      default:  begin mem_addr = cur_q;  mem_wdata = '0; end
    endcase
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign found      = found_q;
  assign error      = err_q;
  assign res_offset = res_q;
  assign res_prev   = prv_q;

  // R3: a reported match is a legal, aligned header offset
  a_r3_found_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (res_offset >= CAP_BASE && res_offset[1:0] == 2'b00));
  // R5: reads only go to aligned offsets inside the extended area (R6 range)
  a_r6_read_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr >= CAP_BASE && mem_addr <= LAST_HDR && mem_addr[1:0] == 2'b00));
  // R9: writes never land outside the extended area
  a_r9_write_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr >= CAP_BASE && mem_addr[1:0] == 2'b00));
  // R8: a read and a write never share a cycle
  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  // R11: a start seen while busy leaves the target untouched
  a_r11_busy_keeps_target: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt_q));
  // R12: a completion never reports both a result and an error
  a_r12_found_xor_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(found && error));
endmodule

// File: tb/ecap_list_walker_bench.sv
`timescale 1ns/1ps
module ecap_list_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_append = 1'b0;
  logic [15:0] target_id = '0;
  logic [11:0] app_offset = '0;
  logic [3:0]  app_version = '0;
  logic [12:0] app_size = '0;
  logic mem_rd_en, mem_wr_en, busy, done, found, error;
  logic [11:0] mem_addr, res_offset, res_prev;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [0:1023];
  int wr_cnt = 0;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  ecap_list_walker u_ecap_list_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .target_id(target_id), .app_offset(app_offset), .app_version(app_version),
    .app_size(app_size), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .found(found), .res_offset(res_offset),
    .res_prev(res_prev), .error(error)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr_en) begin
      mem[mem_addr[11:2]] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  function automatic logic [31:0] hw(input logic [15:0] id, input logic [3:0] v,
                                     input logic [11:0] n);
    return {n, v, id};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic put(input logic [11:0] off, input logic [31:0] w);
    mem[off[11:2]] = w;
  endtask

  task automatic run(input logic app, input logic [15:0] id, input logic [11:0] off,
                     input logic [3:0] ver, input logic [12:0] sz, output int lat);
    @(negedge clk);
    start = 1'b1; op_append = app; target_id = id;
    app_offset = off; app_version = ver; app_size = sz;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 4000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
  endtask

  task automatic search_chk(input string req, input logic [15:0] id,
                            input logic f, input logic [11:0] ro, input logic [11:0] rp,
                            input logic e, input int exp_lat);
    int lat;
    run(1'b0, id, 12'h0, 4'h0, 13'h0, lat);
    chk(req, "latency", lat, exp_lat);
    chk(req, "found", found, f);
    chk(req, "offset", res_offset, ro);
    chk(req, "prev", res_prev, rp);
    chk(req, "error", error, e);
  endtask

  task automatic build_three();
    clear_mem();
    put(12'h100, hw(16'h0001, 4'h1, 12'h200));
    put(12'h200, hw(16'h000b, 4'hf, 12'h300));
    put(12'h300, hw(16'h0010, 4'h2, 12'h000));
  endtask

  task automatic t_reset();
    chk("R12", "done after reset", done, 1'b0);
    chk("R12", "busy after reset", busy, 1'b0);
    chk("R12", "rd_en after reset", mem_rd_en, 1'b0);
    chk("R12", "wr_en after reset", mem_wr_en, 1'b0);
  endtask

  task automatic t_empty();
    clear_mem();
    search_chk("R2", 16'h0005, 1'b0, 12'h0, 12'h0, 1'b0, 3);
  endtask

  task automatic t_walk();
    build_three();
    search_chk("R3", 16'h0010, 1'b1, 12'h300, 12'h200, 1'b0, 7);
    search_chk("R3", 16'h0001, 1'b1, 12'h100, 12'h000, 1'b0, 3);
    // R1: a nonzero version field does not disturb the ID compare
    search_chk("R1", 16'h000b, 1'b1, 12'h200, 12'h100, 1'b0, 5);
    search_chk("R4", 16'h0055, 1'b0, 12'h000, 12'h300, 1'b0, 7);
    search_chk("R4", 16'h0000, 1'b0, 12'h000, 12'h300, 1'b0, 7);
    @(negedge clk);
    chk("R12", "done drops after one cycle", done, 1'b0);
    chk("R12", "result held", res_prev, 12'h300);
  endtask

  task automatic t_bad_ptr();
    clear_mem();
    put(12'h100, hw(16'h0001, 4'h1, 12'h202));
    search_chk("R5", 16'h0009, 1'b0, 12'h0, 12'h0, 1'b1, 3);
    put(12'h100, hw(16'h0001, 4'h1, 12'h0f0));
    search_chk("R6", 16'h0009, 1'b0, 12'h0, 12'h0, 1'b1, 3);
    put(12'h100, hw(16'h0001, 4'h1, 12'hffc));
    search_chk("R6", 16'h0009, 1'b0, 12'h0, 12'h0, 1'b1, 3);
    put(12'h100, hw(16'h0001, 4'h1, 12'hff8));
    put(12'hff8, hw(16'h0007, 4'h1, 12'h000));
    search_chk("R6", 16'h0007, 1'b1, 12'hff8, 12'h100, 1'b0, 5);
  endtask

  task automatic t_loop();
    clear_mem();
    put(12'h100, hw(16'h0001, 4'h1, 12'h100));
    search_chk("R7", 16'h0002, 1'b0, 12'h0, 12'h0, 1'b1, 2049);
  endtask

  task automatic t_append_base();
    int lat, w0;
    build_three();
    w0 = wr_cnt;
    run(1'b1, 16'h0022, 12'h100, 4'h3, 13'd16, lat);
    chk("R8", "latency", lat, 4);
    chk("R8", "writes", wr_cnt - w0, 1);
    chk("R8", "new word", mem[12'h100 >> 2], hw(16'h0022, 4'h3, 12'h200));
    chk("R8", "found/off/prev/err", {found, res_offset, res_prev, error},
        {1'b1, 12'h100, 12'h000, 1'b0});
  endtask

  task automatic t_append_tail();
    int lat, w0;
    clear_mem();
    put(12'h100, hw(16'h0001, 4'h1, 12'h200));
    put(12'h200, hw(16'h000b, 4'h5, 12'h000));
    w0 = wr_cnt;
    run(1'b1, 16'h0033, 12'h400, 4'h2, 13'd16, lat);
    chk("R9", "latency", lat, 7);
    chk("R9", "writes", wr_cnt - w0, 2);
    chk("R9", "tail patched", mem[12'h200 >> 2], hw(16'h000b, 4'h5, 12'h400));
    chk("R9", "new word", mem[12'h400 >> 2], hw(16'h0033, 4'h2, 12'h000));
    chk("R9", "found/off/prev/err", {found, res_offset, res_prev, error},
        {1'b1, 12'h400, 12'h200, 1'b0});
    search_chk("R9", 16'h0033, 1'b1, 12'h400, 12'h200, 1'b0, 7);
  endtask

  task automatic reject(input logic [11:0] off, input logic [12:0] sz, input int exp_lat);
    int lat, w0;
    w0 = wr_cnt;
    run(1'b1, 16'h0044, off, 4'h1, sz, lat);
    chk("R10", "latency", lat, exp_lat);
    chk("R10", "error", error, 1'b1);
    chk("R10", "found", found, 1'b0);
    chk("R10", "no write", wr_cnt - w0, 0);
  endtask

  task automatic t_reject();
    build_three();
    reject(12'h080, 13'd16, 1);
    reject(12'h402, 13'd16, 1);
    reject(12'h400, 13'd4, 1);
    reject(12'hff0, 13'd16, 1);
    clear_mem();
    reject(12'h400, 13'd16, 3);
  endtask

  task automatic t_busy_start();
    int lat;
    build_three();
    @(negedge clk);
    start = 1'b1; op_append = 1'b0; target_id = 16'h0010;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    @(posedge clk); lat++;
    @(negedge clk); start = 1'b1; target_id = 16'h0001;
    @(posedge clk); lat++;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 4000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk("R11", "latency", lat, 7);
    chk("R11", "offset", res_offset, 12'h300);
    chk("R11", "prev", res_prev, 12'h200);
    repeat (4) begin
      @(negedge clk);
      chk("R11", "no second done", done, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_walk();
    t_bad_ptr();
    t_loop();
    t_append_base();
    t_append_tail();
    t_reject();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule